// File: doc/BRIEF.md
# Two-Slot Hot-Plug Power Fault Controller

This block holds the per-slot control logic of a two-slot hot-plug power controller. For each slot it decides whether the main output group and the auxiliary output are switched on. The block also drives the output discharge control and the active-low power-good and fault pins. Each of those pins is modelled as a "drive low" bit, where 1 means pull low and 0 means release. Each slot takes its power requests either from its hardware enable pins or from software enable bits, chosen per slot by a select bit. Analog sensing, timing capacitors, gate drive and the register transport sit outside the block. Over-temperature comparisons and current-regulation timeouts arrive here as digital flags.

Protection is selective. A current-regulation timeout turns off only the group that timed out. A slot over-temperature flag turns off the whole slot. A die over-temperature flag turns off every output of both slots and sets a sticky status bit. Faults stay latched until the request for the affected outputs is withdrawn. A trip on a hardware-controlled slot pulls its fault pin low. A trip on a software-controlled slot instead sets a pending interrupt, which is reported through a maskable request line and cleared by an acknowledge.

A debug force-on pin, active low and passed through a two-flop synchroniser, turns the whole slot on. While it is active it ignores current and slot thermal faults and releases both status pins. A per-slot lock bit makes the slot ignore that pin. The auxiliary output is honoured only after the supply-valid input has been high for a parameterised number of cycles.

Top module: `hp_slot_power_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all main and auxiliary enables are 0, discharge is 1 for each slot, power-good, fault, irq_req and ot_status are 0.
- R2: The request for a slot comes from hw_on/hw_auxen when sw_sel is 0 and from sw_main_en/sw_aux_en when sw_sel is 1. A main request turns main_en on in the cycle after it is sampled.
- R3: aux_en stays 0 until supply_ok has been sampled high on POR_CYCLES consecutive clock edges. With the auxiliary request held, aux_en rises after edge POR_CYCLES+1. A low supply_ok restarts the count.
- R4: A cr_timeout_main pulse while main_en is 1 turns main_en off on the next cycle and leaves aux_en unchanged. A cr_timeout_aux pulse does the same for aux_en and leaves main_en unchanged.
- R5: A latched group fault persists while that group's request stays high. It clears once the request is sampled low, and a later request turns the group back on.
- R6: A slot_ot flag turns off both groups of that slot on the next cycle and leaves the other slot unchanged. The fault stays latched until both requests of the slot are low.
- R7: die_ot turns off every output of both slots on the next cycle, even under force-on. It sets ot_status, which stays 1 until an ot_ack cycle.
- R8: A trip on a slot with sw_sel=0 drives fault_low for that slot. With sw_sel=1, fault_low stays 0 and a pending interrupt is set. irq_req is 1 in the cycle after any slot has an unmasked pending interrupt. irq_ack clears that slot's pending interrupt.
- R9: With force_on_n low and the lock bit clear, both groups are on within three cycles regardless of requests or the start-up delay. Current timeouts and slot_ot are ignored, and pgood_low and fault_low are 0.
- R10: With force_lock set for a slot, its force_on_n pin has no effect on its outputs.
- R11: discharge of a slot is 1 exactly when both of its groups are off.
- R12: pgood_low of a slot is 1 exactly when both groups are on, main_good and aux_good were high at the last edge, and force-on is not active.
- R13: fault_event pulses high for exactly one cycle when a new fault of a slot latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Input supplies are valid |
| force_on_n | input | NUM_SLOTS | Asynchronous active-low force-on per slot |
| force_lock | input | NUM_SLOTS | Ignore force_on_n for the slot |
| sw_sel | input | NUM_SLOTS | 1: software enable bits control the slot |
| hw_on | input | NUM_SLOTS | Hardware main request |
| hw_auxen | input | NUM_SLOTS | Hardware auxiliary request |
| sw_main_en | input | NUM_SLOTS | Software main request |
| sw_aux_en | input | NUM_SLOTS | Software auxiliary request |
| cr_timeout_main | input | NUM_SLOTS | Current-regulation timer expired, main group |
| cr_timeout_aux | input | NUM_SLOTS | Current-regulation timer expired, auxiliary |
| slot_ot | input | NUM_SLOTS | Slot over-temperature flag |
| die_ot | input | 1 | Die over-temperature flag |
| main_good | input | NUM_SLOTS | Main outputs delivering power |
| aux_good | input | NUM_SLOTS | Auxiliary output delivering power |
| irq_mask | input | NUM_SLOTS | Mask pending interrupt of the slot |
| irq_ack | input | NUM_SLOTS | Clear pending interrupt of the slot |
| ot_ack | input | 1 | Clear ot_status |
| main_en | output | NUM_SLOTS | Main group enable |
| aux_en | output | NUM_SLOTS | Auxiliary enable |
| discharge | output | NUM_SLOTS | Output discharge control |
| pgood_low | output | NUM_SLOTS | 1: pull power-good pin low |
| fault_low | output | NUM_SLOTS | 1: pull fault pin low |
| fault_event | output | NUM_SLOTS | One-cycle pulse on a new fault |
| irq_req | output | 1 | Interrupt request |
| ot_status | output | 1 | Sticky die over-temperature status |

## Verification
The assertions assume that every input except force_on_n is synchronous to clk and changes at most once per cycle. They also assume that a current-regulation timeout means something only while its group is on. The stimulus therefore changes every input on the falling edge. The random phase keeps force_on_n released and supply_ok high once the start-up delay has run, so the protection paths decide the outputs without an override. The force, lock and start-up corners are covered by directed sequences.

// File: rtl/hp_pkg.sv
package hp_pkg;
  // latched fault causes of one slot
  typedef struct packed {
    logic die;
    logic slot;
    logic aux;
    logic main;
  } hp_fault_t;

  function automatic int unsigned hp_cnt_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/hp_sync2.sv
module hp_sync2 #(
  parameter int unsigned WIDTH     = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {WIDTH{RESET_VAL}};
      stage2_q <= {WIDTH{RESET_VAL}};
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/hp_por_timer.sv
module hp_por_timer import hp_pkg::*; #(
  parameter int unsigned POR_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic por_done
);
  localparam int unsigned CW = hp_cnt_width(POR_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!supply_ok)
      cnt_q <= '0;
    else if (cnt_q != LIMIT)
      cnt_q <= cnt_q + 1'b1;
  end

  assign por_done = (cnt_q == LIMIT);

  // R3: a dropped supply leaves the delay unfinished on the next cycle
  assert_por_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !por_done);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl import hp_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic por_done,
  input  logic die_ot,
  input  logic force_act,
  input  logic sw_sel,
  input  logic hw_on,
  input  logic hw_auxen,
  input  logic sw_main,
  input  logic sw_aux,
  input  logic cr_to_main,
  input  logic cr_to_aux,
  input  logic slot_ot,
  input  logic main_good,
  input  logic aux_good,
  input  logic irq_ack,
  output logic main_en,
  output logic aux_en,
  output logic discharge,
  output logic pgood_low,
  output logic fault_low,
  output logic fault_event,
  output logic irq_pend
);
  logic      main_req, aux_req;
  hp_fault_t trip, flt_q, flt_d;
  logic      new_trip;
  logic      main_en_q, aux_en_q, main_en_d, aux_en_d;
  logic      disch_q, pgood_q, fault_q, evt_q, pend_q;
  logic      pend_d;

  always_comb begin
    main_req = sw_sel ? sw_main : hw_on;
    aux_req  = sw_sel ? sw_aux  : hw_auxen;

    // trip causes; force-on defeats all but the die flag
    trip.main = cr_to_main & main_en_q & ~force_act;
    trip.aux  = cr_to_aux  & aux_en_q  & ~force_act;
    trip.slot = slot_ot & ~force_act;
    trip.die  = die_ot;

    // a fault holds while its request stays high
    flt_d.main = trip.main | (flt_q.main & main_req);
    flt_d.aux  = trip.aux  | (flt_q.aux  & aux_req);
    flt_d.slot = trip.slot | (flt_q.slot & (main_req | aux_req));
    flt_d.die  = trip.die  | (flt_q.die  & (main_req | aux_req));

    new_trip = |(trip & ~flt_q);

    main_en_d = ~flt_d.die &
                (force_act | (main_req & ~flt_d.main & ~flt_d.slot));
    aux_en_d  = ~flt_d.die &
                (force_act | (aux_req & por_done & ~flt_d.aux & ~flt_d.slot));

    pend_d = (new_trip & sw_sel) | (pend_q & ~irq_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q     <= '0;
      main_en_q <= 1'b0;
      aux_en_q  <= 1'b0;
      disch_q   <= 1'b1;
      pgood_q   <= 1'b0;
      fault_q   <= 1'b0;
      evt_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      flt_q     <= flt_d;
      main_en_q <= main_en_d;
      aux_en_q  <= aux_en_d;
      disch_q   <= ~main_en_d & ~aux_en_d;
      pgood_q   <= ~force_act & main_en_d & aux_en_d & main_good & aux_good;
      fault_q   <= ~force_act & ~sw_sel & (|flt_d);
      evt_q     <= new_trip;
      pend_q    <= pend_d;
    end
  end

  assign main_en     = main_en_q;
  assign aux_en      = aux_en_q;
  assign discharge   = disch_q;
  assign pgood_low   = pgood_q;
  assign fault_low   = fault_q;
  assign fault_event = evt_q;
  assign irq_pend    = pend_q;

  // R4: a main timeout while on shuts the main group next cycle
  assert_main_trip_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_to_main & main_en_q & ~force_act) |=> !main_en_q);

  // R7: die over-temperature wins over every request and force-on
  assert_die_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    die_ot |=> (!main_en_q && !aux_en_q));

  // R3: no auxiliary power before the start-up delay unless forced
  assert_aux_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_done && !force_act) |=> !aux_en_q);

  // R9: force-on releases both status pins
  assert_force_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_act |=> (!pgood_q && !fault_q));

  // R8: a software-controlled slot never pulls its fault pin
  assert_sw_no_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel |=> !fault_q);
endmodule

// File: rtl/hp_slot_power_ctrl.sv
module hp_slot_power_ctrl import hp_pkg::*; #(
  parameter int unsigned NUM_SLOTS  = 2,
  parameter int unsigned POR_CYCLES = 50000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 supply_ok,
  input  logic [NUM_SLOTS-1:0] force_on_n,
  input  logic [NUM_SLOTS-1:0] force_lock,
  input  logic [NUM_SLOTS-1:0] sw_sel,
  input  logic [NUM_SLOTS-1:0] hw_on,
  input  logic [NUM_SLOTS-1:0] hw_auxen,
  input  logic [NUM_SLOTS-1:0] sw_main_en,
  input  logic [NUM_SLOTS-1:0] sw_aux_en,
  input  logic [NUM_SLOTS-1:0] cr_timeout_main,
  input  logic [NUM_SLOTS-1:0] cr_timeout_aux,
  input  logic [NUM_SLOTS-1:0] slot_ot,
  input  logic                 die_ot,
  input  logic [NUM_SLOTS-1:0] main_good,
  input  logic [NUM_SLOTS-1:0] aux_good,
  input  logic [NUM_SLOTS-1:0] irq_mask,
  input  logic [NUM_SLOTS-1:0] irq_ack,
  input  logic                 ot_ack,
  output logic [NUM_SLOTS-1:0] main_en,
  output logic [NUM_SLOTS-1:0] aux_en,
  output logic [NUM_SLOTS-1:0] discharge,
  output logic [NUM_SLOTS-1:0] pgood_low,
  output logic [NUM_SLOTS-1:0] fault_low,
  output logic [NUM_SLOTS-1:0] fault_event,
  output logic                 irq_req,
  output logic                 ot_status
);
  logic                 por_done;
  logic [NUM_SLOTS-1:0] force_n_sync;
  logic [NUM_SLOTS-1:0] force_act;
  logic [NUM_SLOTS-1:0] irq_pend;
  logic                 irq_q, ot_q;

  hp_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .por_done (por_done)
  );

  hp_sync2 #(.WIDTH(NUM_SLOTS), .RESET_VAL(1'b1)) u_force_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(force_on_n),
    .q_sync (force_n_sync)
  );

  assign force_act = ~force_n_sync & ~force_lock;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hp_slot_ctrl u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .por_done   (por_done),
      .die_ot     (die_ot),
      .force_act  (force_act[s]),
      .sw_sel     (sw_sel[s]),
      .hw_on      (hw_on[s]),
      .hw_auxen   (hw_auxen[s]),
      .sw_main    (sw_main_en[s]),
      .sw_aux     (sw_aux_en[s]),
      .cr_to_main (cr_timeout_main[s]),
      .cr_to_aux  (cr_timeout_aux[s]),
      .slot_ot    (slot_ot[s]),
      .main_good  (main_good[s]),
      .aux_good   (aux_good[s]),
      .irq_ack    (irq_ack[s]),
      .main_en    (main_en[s]),
      .aux_en     (aux_en[s]),
      .discharge  (discharge[s]),
      .pgood_low  (pgood_low[s]),
      .fault_low  (fault_low[s]),
      .fault_event(fault_event[s]),
      .irq_pend   (irq_pend[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ot_q  <= 1'b0;
    end else begin
      irq_q <= |(irq_pend & ~irq_mask);
      ot_q  <= die_ot | (ot_q & ~ot_ack);
    end
  end

  assign irq_req   = irq_q;
  assign ot_status = ot_q;

  // R7: the die over-temperature status is sticky until acknowledged
  assert_ot_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && !ot_ack) |=> ot_q);

  // R8: a fully masked set of pending interrupts raises no request
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend & ~irq_mask) == '0) |=> !irq_q);
endmodule

// File: tb/tb_hp_slot_power_ctrl.sv
module tb_hp_slot_power_ctrl;
  localparam int N   = 2;
  localparam int POR = 20;
  localparam time HALF = 2.5ns;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, die_ot, ot_ack;
  logic [N-1:0] force_on_n, force_lock, sw_sel, hw_on, hw_auxen;
  logic [N-1:0] sw_main_en, sw_aux_en, cr_timeout_main, cr_timeout_aux;
  logic [N-1:0] slot_ot, main_good, aux_good, irq_mask, irq_ack;
  logic [N-1:0] main_en, aux_en, discharge, pgood_low, fault_low, fault_event;
  logic irq_req, ot_status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  hp_slot_power_ctrl #(.NUM_SLOTS(N), .POR_CYCLES(POR)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .force_on_n(force_on_n), .force_lock(force_lock), .sw_sel(sw_sel),
    .hw_on(hw_on), .hw_auxen(hw_auxen), .sw_main_en(sw_main_en),
    .sw_aux_en(sw_aux_en), .cr_timeout_main(cr_timeout_main),
    .cr_timeout_aux(cr_timeout_aux), .slot_ot(slot_ot), .die_ot(die_ot),
    .main_good(main_good), .aux_good(aux_good), .irq_mask(irq_mask),
    .irq_ack(irq_ack), .ot_ack(ot_ack), .main_en(main_en), .aux_en(aux_en),
    .discharge(discharge), .pgood_low(pgood_low), .fault_low(fault_low),
    .fault_event(fault_event), .irq_req(irq_req), .ot_status(ot_status)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected discharge: slot fully off
  function automatic logic exp_disch(input logic m, input logic a);
    return ~m & ~a;
  endfunction

  // expected power-good pull-down with force-on released
  function automatic logic exp_pgood(input logic m, input logic a,
                                     input logic mg, input logic ag);
    return m & a & mg & ag;
  endfunction

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; supply_ok = 0; die_ot = 0; ot_ack = 0;
    force_on_n = '1; force_lock = '0; sw_sel = '0; hw_on = '0; hw_auxen = '0;
    sw_main_en = '0; sw_aux_en = '0; cr_timeout_main = '0; cr_timeout_aux = '0;
    slot_ot = '0; main_good = '0; aux_good = '0; irq_mask = '0; irq_ack = '0;
    tick(3);
    // R1 reset state
    check("R1 main_en", 8'(main_en), 8'h0);
    check("R1 aux_en", 8'(aux_en), 8'h0);
    check("R1 discharge", 8'(discharge), 8'h3);
    check("R1 pins", {2'b0, pgood_low, fault_low, irq_req, ot_status}, 8'h0);

    rst_n = 1; supply_ok = 1; hw_on[0] = 1; hw_auxen[0] = 1;
    tick(1);
    check("R2 hw main on", 8'(main_en), 8'h1);
    check("R3 aux early", 8'(aux_en), 8'h0);
    tick(POR - 1);
    check("R3 aux before delay", 8'(aux_en[0]), 8'h0);
    tick(1);
    check("R3 aux after delay", 8'(aux_en[0]), 8'h1);
    check("R11 slot1 discharge", 8'(discharge[1]), 8'h1);

    main_good[0] = 1; aux_good[0] = 1;
    tick(1);
    check("R12 pgood on", 8'(pgood_low[0]), 8'h1);
    check("R11 slot0 live", 8'(discharge[0]), 8'h0);

    // R4 main group timeout
    cr_timeout_main[0] = 1;
    tick(1);
    check("R4 main off", 8'(main_en[0]), 8'h0);
    check("R4 aux kept", 8'(aux_en[0]), 8'h1);
    check("R8 hw fault pin", 8'(fault_low[0]), 8'h1);
    check("R13 event", 8'(fault_event[0]), 8'h1);
    check("R12 pgood dropped", 8'(pgood_low[0]), 8'h0);
    cr_timeout_main[0] = 0;
    tick(1);
    check("R13 one pulse", 8'(fault_event[0]), 8'h0);
    check("R5 latched", 8'(main_en[0]), 8'h0);
    hw_on[0] = 0;
    tick(1);
    check("R5 cleared pin", 8'(fault_low[0]), 8'h0);
    hw_on[0] = 1;
    tick(1);
    check("R5 main back", 8'(main_en[0]), 8'h1);

    // R4 auxiliary timeout
    cr_timeout_aux[0] = 1;
    tick(1);
    cr_timeout_aux[0] = 0;
    check("R4 aux off", 8'(aux_en[0]), 8'h0);
    check("R4 main kept", 8'(main_en[0]), 8'h1);
    hw_auxen[0] = 0; tick(1);
    hw_auxen[0] = 1; tick(1);
    check("R5 aux back", 8'(aux_en[0]), 8'h1);

    // R6 slot over-temperature
    hw_on[1] = 1; hw_auxen[1] = 1;
    tick(1);
    check("R2 slot1 on", {6'b0, main_en[1], aux_en[1]}, 8'h3);
    slot_ot[0] = 1;
    tick(1);
    slot_ot[0] = 0;
    check("R6 slot0 off", {6'b0, main_en[0], aux_en[0]}, 8'h0);
    check("R6 slot1 kept", {6'b0, main_en[1], aux_en[1]}, 8'h3);
    tick(1);
    check("R6 latched", {6'b0, main_en[0], aux_en[0]}, 8'h0);
    hw_on[0] = 0; hw_auxen[0] = 0; tick(1);
    hw_on[0] = 1; hw_auxen[0] = 1; tick(1);
    check("R6 restored", {6'b0, main_en[0], aux_en[0]}, 8'h3);

    // R8 software path
    sw_sel[1] = 1; sw_main_en[1] = 1; sw_aux_en[1] = 1;
    tick(1);
    check("R2 sw path on", {6'b0, main_en[1], aux_en[1]}, 8'h3);
    cr_timeout_main[1] = 1;
    tick(1);
    cr_timeout_main[1] = 0;
    check("R8 sw main off", 8'(main_en[1]), 8'h0);
    check("R8 sw no pin", 8'(fault_low[1]), 8'h0);
    tick(1);
    check("R8 irq raised", 8'(irq_req), 8'h1);
    irq_mask[1] = 1; tick(1);
    check("R8 irq masked", 8'(irq_req), 8'h0);
    irq_mask[1] = 0; tick(1);
    check("R8 irq unmasked", 8'(irq_req), 8'h1);
    irq_ack[1] = 1; tick(1);
    irq_ack[1] = 0; tick(1);
    check("R8 irq acked", 8'(irq_req), 8'h0);
    sw_main_en[1] = 0; tick(1);
    sw_main_en[1] = 1; tick(1);
    check("R5 sw clear", 8'(main_en[1]), 8'h1);

    // R9 force-on
    sw_main_en[1] = 0; sw_aux_en[1] = 0; main_good[1] = 1; aux_good[1] = 1;
    tick(1);
    check("R2 sw off", {6'b0, main_en[1], aux_en[1]}, 8'h0);
    force_on_n[1] = 0;
    tick(3);
    check("R9 forced on", {6'b0, main_en[1], aux_en[1]}, 8'h3);
    check("R9 pins released", {6'b0, pgood_low[1], fault_low[1]}, 8'h0);
    cr_timeout_main[1] = 1; slot_ot[1] = 1;
    tick(1);
    cr_timeout_main[1] = 0; slot_ot[1] = 0;
    check("R9 faults ignored", {6'b0, main_en[1], aux_en[1]}, 8'h3);
    force_lock[1] = 1;
    tick(1);
    check("R10 locked", {6'b0, main_en[1], aux_en[1]}, 8'h0);
    force_on_n[1] = 1; force_lock[1] = 0;
    tick(3);

    // R7 die over-temperature under force-on of slot1
    force_on_n[1] = 0;
    tick(3);
    die_ot = 1;
    tick(1);
    die_ot = 0;
    check("R7 all main off", 8'(main_en), 8'h0);
    check("R7 all aux off", 8'(aux_en), 8'h0);
    check("R7 status set", 8'(ot_status), 8'h1);
    force_on_n[1] = 1;
    tick(3);
    check("R7 sticky", 8'(ot_status), 8'h1);
    check("R7 slot0 latched", 8'(main_en[0]), 8'h0);
    ot_ack = 1; tick(1);
    ot_ack = 0;
    check("R7 acked", 8'(ot_status), 8'h0);
    hw_on[0] = 0; hw_auxen[0] = 0; tick(1);
    hw_on[0] = 1; hw_auxen[0] = 1; tick(1);
    check("R7 restored", {6'b0, main_en[0], aux_en[0]}, 8'h3);

    // random phase, force-on released
    void'($urandom(32'd2024));
    for (int cyc = 0; cyc < 3000; cyc++) begin
      logic die_prev;
      die_prev = die_ot;
      tick(1);
      for (int s = 0; s < N; s++) begin
        check("R11 rand", 8'(discharge[s]), 8'(exp_disch(main_en[s], aux_en[s])));
        check("R12 rand", 8'(pgood_low[s]),
              8'(exp_pgood(main_en[s], aux_en[s], main_good[s], aux_good[s])));
        if (sw_sel[s]) check("R8 rand sw pin", 8'(fault_low[s]), 8'h0);
        if (die_prev) check("R7 rand off", {6'b0, main_en[s], aux_en[s]}, 8'h0);
      end
      sw_sel          = N'($urandom_range(0, 3));
      hw_on           = N'($urandom_range(0, 3)) | N'($urandom_range(0, 3));
      hw_auxen        = N'($urandom_range(0, 3)) | N'($urandom_range(0, 3));
      sw_main_en      = N'($urandom_range(0, 3)) | N'($urandom_range(0, 3));
      sw_aux_en       = N'($urandom_range(0, 3)) | N'($urandom_range(0, 3));
      main_good       = N'($urandom_range(0, 3)) | N'($urandom_range(0, 3));
      aux_good        = N'($urandom_range(0, 3)) | N'($urandom_range(0, 3));
      cr_timeout_main = ($urandom_range(0, 15) == 0) ? N'($urandom_range(1, 3)) : '0;
      cr_timeout_aux  = ($urandom_range(0, 15) == 0) ? N'($urandom_range(1, 3)) : '0;
      slot_ot         = ($urandom_range(0, 31) == 0) ? N'($urandom_range(1, 3)) : '0;
      die_ot          = ($urandom_range(0, 63) == 0);
      force_lock      = N'($urandom_range(0, 3));
      irq_mask        = N'($urandom_range(0, 3));
      irq_ack         = N'($urandom_range(0, 3));
      ot_ack          = ($urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule